// File: doc/BRIEF.md
# Framed Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on a single output line. A character is written with a one-cycle load strobe into a one-entry holding register. The transmitter moves it into its shifter as soon as the line is free, or on the same edge that ends the previous frame. The character then goes out as a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and 1, 1.5 or 2 stop bits.

An 8-bit framing word sets the character length, the stop length, the parity mode (none, odd, even, forced one, forced zero) and a break override. The caller supplies a baud tick enable at 16 times the bit rate. Every bit lasts a fixed number of ticks. The framing fields, apart from the break bit, are sampled once, when a frame starts. The break bit pulls the line low at once and does not stop the sequencing.

Top module: `sertx_top`

## Requirements
- R1: Out of reset, and whenever no frame is in progress and break is clear, `txd_o` is 1, `busy_o` is 0 and `hold_empty_o` is 1.
- R2: A frame starts with one start bit at 0, followed by the data bits least significant first. Each of these bits lasts `TICKS_PER_BIT` (16) asserted `baud_tick_i` cycles.
- R3: `ctrl_i[1:0]` sets the character length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits. Byte bits above the selected length are not sent and do not affect parity.
- R4: Stop bits are driven at 1. With `ctrl_i[2]`=0 the stop time is 16 ticks. With `ctrl_i[2]`=1 it is 24 ticks for 5-bit characters and 32 ticks for longer ones.
- R5: With `ctrl_i[3]`=1 and `ctrl_i[5]`=0, a parity bit follows the last data bit. `ctrl_i[4]`=1 makes the count of ones in data plus parity even, and `ctrl_i[4]`=0 makes it odd. With `ctrl_i[3]`=0 no parity bit is sent.
- R6: With `ctrl_i[3]`=1 and `ctrl_i[5]`=1, the parity bit is the constant inverse of `ctrl_i[4]`: 1 when bit 4 is 0, and 0 when bit 4 is 1.
- R7: While `ctrl_i[6]`=1, `txd_o` is 0 in the same cycle, whatever the transmitter is doing. The frame timing keeps running underneath, and the line shows the frame's current bit again once bit 6 clears.
- R8: A load strobe makes `hold_empty_o` 0 from the next cycle. A load while the holding register is full replaces the held byte. `busy_o` rises on the edge after which a held byte is taken while idle.
- R9: When a byte is held as a frame's stop time ends, its start bit begins on that same edge, so `busy_o` stays 1 between the two frames.
- R10: `ctrl_i[5:0]` are sampled when a frame starts. Changing them mid-frame does not affect the frame in progress.
- R11: `ctrl_i[7]` has no effect on the line, `busy_o` or `hold_empty_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| baud_tick_i | input | 1 | Enable at 16 times the bit rate |
| load_i | input | 1 | Strobe that writes `data_i` into the holding register |
| data_i | input | 8 | Character to send |
| ctrl_i | input | 8 | Framing word: length, stop, parity enable, even select, forced parity, break, spare |
| txd_o | output | 1 | Serial output line, idles at 1 |
| busy_o | output | 1 | A frame is being sent |
| hold_empty_o | output | 1 | The holding register can accept a byte |

## Verification
The bench sweeps all 40 combinations of character length, stop setting and parity mode with data whose upper bits are set. A design that sized the half stop bit wrongly, used the wrong polarity for forced parity, or folded unsent bits into parity would put a wrong line value at a specific tick. It overwrites a held byte and loads back to back. A design that left an idle gap between frames, or sent the replaced byte, would drop `busy_o` or send the wrong bits. Break is asserted in the middle of a frame and the framing word is changed mid-frame. A design that froze the shifter during break, or read the framing fields live, would fall out of step with the model after break is released.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic [1:0] len;       // 0..3 -> 5..8 data bits
        logic       long_stop;
        logic       par_en;
        logic       par_even;
        logic       stick;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_cfg(input logic [5:0] raw);
        frame_cfg_t c;
        c.len       = raw[1:0];
        c.long_stop = raw[2];
        c.par_en    = raw[3];
        c.par_even  = raw[4];
        c.stick     = raw[5];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
        return {DATA_W{1'b1}} >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [DW-1:0] din_i,
    input  logic          take_i,
    output logic          full_o,
    output logic [DW-1:0] data_o
);

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take_i) begin
            hold_d.full = 1'b0;
        end
        if (load_i) begin
            hold_d.full = 1'b1;
            hold_d.data = din_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full_o = hold_q.full;
    assign data_o = hold_q.data;

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity
    import sertx_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  frame_cfg_t        cfg_i,
    output logic              par_o
);

    always_comb begin
        if (cfg_i.stick) begin
            par_o = ~cfg_i.par_even;
        end else if (cfg_i.par_even) begin
            par_o = ^data_i;
        end else begin
            par_o = ~(^data_i);
        end
    end

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              avail_i,
    input  logic [DATA_W-1:0] data_i,
    input  frame_cfg_t        cfg_i,
    output logic              take_o,
    output logic              line_o,
    output logic              busy_o
);

    localparam int HALF    = TICKS_PER_BIT / 2;
    localparam int LONGEST = 2 * TICKS_PER_BIT;
    localparam int CNT_W   = $clog2(LONGEST);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        idx;
        logic [DATA_W-1:0] shreg;
        logic              par;
        frame_cfg_t        cfg;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic [DATA_W-1:0] masked;
    logic              par_bit;
    logic [CNT_W-1:0]  last_tick;
    logic              launch;

    assign masked = data_i & len_mask(cfg_i.len);

    sertx_parity u_par (
        .data_i (masked),
        .cfg_i  (cfg_i),
        .par_o  (par_bit)
    );

    always_comb begin
        if (seq_q.phase == PH_STOP && seq_q.cfg.long_stop) begin
            last_tick = (seq_q.cfg.len == 2'd0) ? CNT_W'(TICKS_PER_BIT + HALF - 1)
                                                : CNT_W'(LONGEST - 1);
        end else begin
            last_tick = CNT_W'(TICKS_PER_BIT - 1);
        end
    end

    always_comb begin
        seq_d  = seq_q;
        launch = 1'b0;
        if (seq_q.phase == PH_IDLE) begin
            launch = avail_i;
        end else if (tick_i) begin
            if (seq_q.cnt == last_tick) begin
                seq_d.cnt = '0;
                unique case (seq_q.phase)
                    PH_START: begin
                        seq_d.phase = PH_DATA;
                        seq_d.idx   = '0;
                    end
                    PH_DATA: begin
                        if (seq_q.idx == ({1'b0, seq_q.cfg.len} + 3'd4)) begin
                            seq_d.phase = seq_q.cfg.par_en ? PH_PAR : PH_STOP;
                        end else begin
                            seq_d.idx   = seq_q.idx + 3'd1;
                            seq_d.shreg = seq_q.shreg >> 1;
                        end
                    end
                    PH_PAR: begin
                        seq_d.phase = PH_STOP;
                    end
                    default: begin
                        seq_d.phase = PH_IDLE;
                        launch      = avail_i;
                    end
                endcase
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
        if (launch) begin
            seq_d.phase = PH_START;
            seq_d.cnt   = '0;
            seq_d.idx   = '0;
            seq_d.shreg = masked;
            seq_d.par   = par_bit;
            seq_d.cfg   = cfg_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        unique case (seq_q.phase)
            PH_START: line_o = 1'b0;
            PH_DATA:  line_o = seq_q.shreg[0];
            PH_PAR:   line_o = seq_q.par;
            default:  line_o = 1'b1;
        endcase
    end

    assign take_o = launch;
    assign busy_o = (seq_q.phase != PH_IDLE);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       baud_tick_i,
    input  logic       load_i,
    input  logic [7:0] data_i,
    input  logic [7:0] ctrl_i,
    output logic       txd_o,
    output logic       busy_o,
    output logic       hold_empty_o
);

    logic              held_full;
    logic [DATA_W-1:0] held_data;
    logic              take;
    logic              line;
    frame_cfg_t        cfg;
    logic              ctrl_unused;

    assign cfg         = decode_cfg(ctrl_i[5:0]);
    assign ctrl_unused = ctrl_i[7];

    sertx_hold #(.DW(DATA_W)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load_i),
        .din_i  (data_i),
        .take_i (take),
        .full_o (held_full),
        .data_o (held_data)
    );

    sertx_seq #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (baud_tick_i),
        .avail_i (held_full),
        .data_i  (held_data),
        .cfg_i   (cfg),
        .take_o  (take),
        .line_o  (line),
        .busy_o  (busy_o)
    );

    assign txd_o        = ctrl_i[6] ? 1'b0 : line;
    assign hold_empty_o = ~held_full;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       load_i,
    input logic [7:0] ctrl_i,
    input logic       txd_o,
    input logic       busy_o,
    input logic       hold_empty_o
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !ctrl_i[6]) |-> txd_o);

    // R2
    start_bit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !txd_o);

    // R4
    stop_before_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(busy_o) && !$past(ctrl_i[6])) |-> $past(txd_o));

    // R8
    load_fills_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !hold_empty_o);

    // R8
    idle_takes_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !hold_empty_o) |=> busy_o);

endmodule

bind sertx_top sertx_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .ctrl_i       (ctrl_i),
    .txd_o        (txd_o),
    .busy_o       (busy_o),
    .hold_empty_o (hold_empty_o)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       load = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] ctrl = 8'h00;
    logic       txd, busy, hold_empty;

    int    n_checks = 0;
    int    n_fail = 0;
    int    tick_div = 1;
    int    cycles = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_test = "R1";

    always #5 clk = ~clk;

    sertx_top dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .baud_tick_i  (tick),
        .load_i       (load),
        .data_i       (din),
        .ctrl_i       (ctrl),
        .txd_o        (txd),
        .busy_o       (busy),
        .hold_empty_o (hold_empty)
    );

    // behavioural reference: a list of line segments per frame
    bit        qb[$];
    int        qt[$];
    string     qg[$];
    bit        m_active = 1'b0;
    bit        m_full = 1'b0;
    bit        old_full, took;
    logic [7:0] m_data = 8'h00;
    int        cur_left = 0;
    int        frames = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d t=%0t",
                     req, cur_test, what, act, exp, $time);
        end
    endtask

    task automatic build(input logic [7:0] d, input logic [7:0] c);
        int  n = 5 + int'(c[1:0]);
        bit  ones = 1'b0;
        qb.push_back(1'b0); qt.push_back(16); qg.push_back("R2");
        for (int i = 0; i < n; i++) begin
            qb.push_back(d[i]); qt.push_back(16); qg.push_back("R3");
            ones ^= d[i];
        end
        if (c[3]) begin
            if (c[5]) begin
                qb.push_back(!c[4]); qt.push_back(16); qg.push_back("R6");
            end else begin
                qb.push_back(c[4] ? ones : !ones); qt.push_back(16); qg.push_back("R5");
            end
        end
        qb.push_back(1'b1);
        qt.push_back(c[2] ? ((n == 5) ? 24 : 32) : 16);
        qg.push_back("R4");
        m_active = 1'b1;
        cur_left = qt[0];
        frames++;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            qb.delete(); qt.delete(); qg.delete();
            m_active = 1'b0; m_full = 1'b0; cur_left = 0;
        end else begin
            old_full = m_full;
            took = 1'b0;
            if (m_active) begin
                if (tick) begin
                    cur_left--;
                    if (cur_left == 0) begin
                        void'(qb.pop_front()); void'(qt.pop_front()); void'(qg.pop_front());
                        if (qb.size() == 0) begin
                            m_active = 1'b0;
                            if (old_full) begin
                                build(m_data, ctrl);
                                took = 1'b1;
                            end
                        end else begin
                            cur_left = qt[0];
                        end
                    end
                end
            end else if (old_full) begin
                build(m_data, ctrl);
                took = 1'b1;
            end
            if (load) begin
                m_full = 1'b1;
                m_data = din;
            end else if (took) begin
                m_full = 1'b0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            bit    exp_txd;
            string tag;
            if (ctrl[6]) begin
                exp_txd = 1'b0; tag = "R7";
            end else if (m_active) begin
                exp_txd = qb[0]; tag = qg[0];
            end else begin
                exp_txd = 1'b1; tag = "R1";
            end
            chk(txd == exp_txd, tag, "txd", int'(txd), int'(exp_txd));
            chk(busy == m_active, "R8", "busy", int'(busy), int'(m_active));
            chk(hold_empty == !m_full, "R8", "hold_empty", int'(hold_empty), int'(!m_full));
        end
    end

    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k++;
            tick = ((k % tick_div) == 0);
        end
    end

    task automatic send(input logic [7:0] d);
        while (!hold_empty) @(negedge clk);
        din  = d;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_active || m_full) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int busy_low;
        int f0;
        repeat (4) @(negedge clk);
        // R1: state held in reset
        chk(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
        chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        chk(hold_empty == 1'b1, "R1", "reset hold_empty", int'(hold_empty), 1);
        rst_n = 1'b1;
        chk_on = 1'b1;
        repeat (3) @(negedge clk);

        // R3 R4 R5 R6: full framing sweep with upper data bits set
        cur_test = "R3";
        for (int len = 0; len < 4; len++) begin
            for (int st = 0; st < 2; st++) begin
                for (int pm = 0; pm < 5; pm++) begin
                    logic [7:0] c;
                    logic [2:0] pbits;
                    case (pm)
                        0: pbits = 3'b000;
                        1: pbits = 3'b001;
                        2: pbits = 3'b011;
                        3: pbits = 3'b101;
                        default: pbits = 3'b111;
                    endcase
                    c = {2'b00, pbits, st[0], len[1:0]};
                    ctrl = c;
                    send(8'hE5 ^ 8'((len * 40 + st * 20 + pm) * 37));
                    wait_idle();
                end
            end
        end

        // R2: slower tick cadence
        cur_test = "R2";
        tick_div = 3;
        ctrl = 8'h1B;
        send(8'h96);
        wait_idle();
        tick_div = 1;

        // R8 R9: back-to-back with overwrite of the held byte
        cur_test = "R9";
        ctrl = 8'h03;
        f0 = frames;
        send(8'h3C);
        while (!busy) @(negedge clk);
        send(8'hAA);
        din = 8'h5F;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        busy_low = 0;
        while (m_active || m_full) begin
            if (!busy) busy_low++;
            @(negedge clk);
        end
        chk(busy_low == 0, "R9", "busy low cycles between frames", busy_low, 0);
        chk(frames - f0 == 2, "R8", "frames sent after overwrite", frames - f0, 2);
        wait_idle();

        // R7: break mid-frame, then release
        cur_test = "R7";
        ctrl = 8'h0B;
        send(8'h81);
        repeat (40) @(negedge clk);
        ctrl[6] = 1'b1;
        repeat (50) @(negedge clk);
        chk(busy == 1'b1, "R7", "busy during break", int'(busy), 1);
        ctrl[6] = 1'b0;
        wait_idle();
        ctrl[6] = 1'b1;
        repeat (5) @(negedge clk);
        ctrl[6] = 1'b0;
        repeat (3) @(negedge clk);

        // R10: framing changed mid-frame
        cur_test = "R10";
        ctrl = 8'h0F;
        send(8'hC3);
        repeat (30) @(negedge clk);
        ctrl = 8'h30;
        wait_idle();

        // R11: spare control bit set
        cur_test = "R11";
        ctrl = 8'h9A;
        send(8'h4D);
        wait_idle();
        chk(txd == 1'b1, "R11", "idle txd with spare bit", int'(txd), 1);

        done = 1'b1;
        finish_run();
    end

endmodule